// File: doc/BRIEF.md
# Multi-Source Chip Reset Sequencer

This block controls the chip-wide reset. A reset can come from power-up (the synchronous `rst` input), from a core halt caused by an unrecoverable fault, or from a JTAG request raised while a boundary-drive instruction is active. When the sequencer accepts a reset, it pulls the active-low reset output low in the next cycle. At the same time it latches the wake-configuration pin. It also latches the two PLL-configuration pins, but only if the reset-config strap is high.

The sequencer then waits for the PLL lock input. After lock it counts a parameterised number of cycles. At the end of the count it samples the wake pin, and it samples the boot pins if the strap is high. Four cycles later it releases the reset output and updates a status register. How the status register changes depends on the source of the reset.

A small register port holds two registers. The control word includes the enable bit for checkstop resets. The status register is read-only.

Top module: `reset_sequencer`

## Requirements
- R1: When `rst` is released, a power-up sequence is already in progress with `rst_n_o` low. When that sequence completes, the source bits of the status register read power-up=1 and checkstop=0.
- R2: `rst_n_o` goes low in the cycle after a reset request is accepted. In that same cycle `wake_cfg_o` takes the wake pin. `pll_cfg_o` takes the PLL pins only when `strap_cfg_i`=1; otherwise it keeps its previous value.
- R3: Counting starts only once `pll_lock_i` is seen high. The count lasts HOLD_CYCLES cycles. If lock drops during the count, the count starts again from zero after lock returns. Each cycle of lock low before counting adds one cycle to the sequence. A drop seen k cycles into the count adds k+1 cycles.
- R4: At the end of the count, `wake_cfg_o` takes the wake pin. `boot_cfg_o` takes the boot pins only when `strap_cfg_i`=1; otherwise it keeps its previous value. Pin changes made after the reset begins are therefore visible in the result.
- R5: After the count the sequencer waits exactly 4 cycles and then releases the reset. With lock held high, a checkstop reset keeps `rst_n_o` low for HOLD_CYCLES+5 cycles.
- R6: A checkstop reset starts only when `core_halt_i`=1 and control bit 0 (checkstop enable) is set.
- R7: When a checkstop reset completes, status bit 1 (checkstop) is set and status bit 0 (power-up) is cleared.
- R8: A JTAG request is `tap_en_i`&`tap_bsel_i`. Counting starts only after the request has dropped. If the request is held for H accepted cycles, `rst_n_o` stays low for H+HOLD_CYCLES+4 cycles. With `tap_en_i`=0, no reset occurs.
- R9: When a JTAG reset completes, status bits 1:0 are unchanged. Status bit 2 (wake) and bits 4:3 (boot) take the sampled configuration.
- R10: Requests that arrive while a sequence is running are ignored. They change neither its length nor the status it records.
- R11: If a checkstop request and a JTAG request are valid in the same cycle, the checkstop wins. That sequence then does not wait for the JTAG request to drop.
- R12: Address 0 is the control word, which reads back what was written. Address 1 is the status register, which ignores writes. `reg_rdata_o` shows the addressed register one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| pll_lock_i | input | 1 | PLL lock indication |
| core_halt_i | input | 1 | Core checkstop indication |
| tap_en_i | input | 1 | JTAG port enabled |
| tap_bsel_i | input | 1 | Boundary-drive instruction active |
| strap_cfg_i | input | 1 | Reset-config strap; enables PLL and boot pin capture |
| wake_pin_i | input | 1 | Wake-configuration pin |
| pll_pin_i | input | 2 | PLL-configuration pins |
| boot_pin_i | input | 2 | Boot-configuration pins |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 1 | Register address (0 control, 1 status) |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Registered read data |
| rst_n_o | output | 1 | Active-low reset output |
| wake_cfg_o | output | 1 | Applied wake configuration |
| pll_cfg_o | output | 2 | Applied PLL configuration |
| boot_cfg_o | output | 2 | Sampled boot configuration |

## Verification
Two conditions are hard to create: a lock loss in the middle of the count, and a pin change between the start of the reset and the end of the count. Both happen deep inside a sequence that gives no sign of its progress at the ports. The bench therefore counts cycles from the falling edge of the reset output. It drops lock, or swaps every pin, at a fixed cycle index, and it predicts the resulting low time arithmetically. It sweeps every pin pattern under both strap settings. It also places conflicting or late requests at fixed cycle offsets, which covers priority and the ignore rule.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_COUNT  = 2'd2,
    ST_SETTLE = 2'd3
  } rs_state_t;

  typedef enum logic [1:0] {
    SRC_POR = 2'd0,
    SRC_CHK = 2'd1,
    SRC_TAP = 2'd2
  } rs_src_t;

  localparam int SETTLE_CYCLES = 4;
  localparam int STAT_POR      = 0;
  localparam int STAT_CHK      = 1;
  localparam int STAT_WAKE     = 2;
  localparam int STAT_BOOT     = 3;
  localparam int STAT_W        = 5;
endpackage

// File: rtl/rs_tick.sv
module rs_tick #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= q + W'(1);
  end
endmodule

// File: rtl/rs_fsm.sv
module rs_fsm
  import rs_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      lock,
  input  logic      chk_req,
  input  logic      tap_req,
  output rs_state_t state,
  output rs_src_t   src,
  output logic      rst_n,
  output logic      start,
  output logic      sample,
  output logic      done
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_CYCLES - 1);
  localparam logic [SW-1:0] SET_LAST = SW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] set_q;
  logic          tap_block;

  rs_tick #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .clr(state != ST_COUNT), .en(state == ST_COUNT), .q(cnt_q)
  );
  rs_tick #(.W(SW)) u_set (
    .clk(clk), .rst(rst), .clr(state != ST_SETTLE), .en(state == ST_SETTLE), .q(set_q)
  );

  always_comb begin
    start     = (state == ST_IDLE) && (chk_req || tap_req);
    sample    = (state == ST_COUNT) && lock && (cnt_q == CNT_LAST);
    done      = (state == ST_SETTLE) && (set_q == SET_LAST);
    tap_block = (src == SRC_TAP) && tap_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_WAIT;
      src   <= SRC_POR;
      rst_n <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (chk_req) begin
            state <= ST_WAIT;
            src   <= SRC_CHK;
            rst_n <= 1'b0;
          end else if (tap_req) begin
            state <= ST_WAIT;
            src   <= SRC_TAP;
            rst_n <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (lock && !tap_block) state <= ST_COUNT;
        end
        ST_COUNT: begin
          if (!lock)       state <= ST_WAIT;
          else if (sample) state <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (done) begin
            state <= ST_IDLE;
            rst_n <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rs_cfg_latch.sv
module rs_cfg_latch (
  input  logic       clk,
  input  logic       rst,
  input  logic       strap,
  input  logic       wake_pin,
  input  logic [1:0] pll_pin,
  input  logic [1:0] boot_pin,
  input  logic       start,
  input  logic       sample,
  output logic       wake_cfg,
  output logic [1:0] pll_cfg,
  output logic [1:0] boot_cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wake_cfg <= wake_pin;
      pll_cfg  <= strap ? pll_pin : 2'b00;
      boot_cfg <= 2'b00;
    end else begin
      if (start) begin
        wake_cfg <= wake_pin;
        if (strap) pll_cfg <= pll_pin;
      end else if (sample) begin
        wake_cfg <= wake_pin;
        if (strap) boot_cfg <= boot_pin;
      end
    end
  end
endmodule

// File: rtl/rs_regs.sv
module rs_regs
  import rs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              addr,
  input  logic [DW-1:0]     wdata,
  input  logic              done,
  input  rs_src_t           src,
  input  logic              wake_cfg,
  input  logic [1:0]        boot_cfg,
  output logic              chk_en,
  output logic [STAT_W-1:0] status,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] ctrl_q;

  assign chk_en = ctrl_q[0];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (we && !addr) ctrl_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
    end else if (done) begin
      status[STAT_WAKE]             <= wake_cfg;
      status[STAT_BOOT+1:STAT_BOOT] <= boot_cfg;
      case (src)
        SRC_POR: begin status[STAT_POR] <= 1'b1; status[STAT_CHK] <= 1'b0; end
        SRC_CHK: begin status[STAT_POR] <= 1'b0; status[STAT_CHK] <= 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= addr ? DW'(status) : ctrl_q;
  end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rs_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pll_lock_i,
  input  logic          core_halt_i,
  input  logic          tap_en_i,
  input  logic          tap_bsel_i,
  input  logic          strap_cfg_i,
  input  logic          wake_pin_i,
  input  logic [1:0]    pll_pin_i,
  input  logic [1:0]    boot_pin_i,
  input  logic          reg_we_i,
  input  logic          reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          rst_n_o,
  output logic          wake_cfg_o,
  output logic [1:0]    pll_cfg_o,
  output logic [1:0]    boot_cfg_o
);
  rs_state_t         st;
  rs_src_t           src;
  logic              start, sample, done, chk_en;
  logic              chk_req, tap_req;
  logic [STAT_W-1:0] stat;

  assign chk_req = core_halt_i && chk_en;
  assign tap_req = tap_en_i && tap_bsel_i;

  rs_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .lock(pll_lock_i), .chk_req(chk_req), .tap_req(tap_req),
    .state(st), .src(src), .rst_n(rst_n_o), .start(start), .sample(sample), .done(done)
  );

  rs_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .strap(strap_cfg_i), .wake_pin(wake_pin_i),
    .pll_pin(pll_pin_i), .boot_pin(boot_pin_i), .start(start), .sample(sample),
    .wake_cfg(wake_cfg_o), .pll_cfg(pll_cfg_o), .boot_cfg(boot_cfg_o)
  );

  rs_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
    .done(done), .src(src), .wake_cfg(wake_cfg_o), .boot_cfg(boot_cfg_o),
    .chk_en(chk_en), .status(stat), .rdata(reg_rdata_o)
  );
endmodule

// File: rtl/rs_checker.sv
module rs_checker
  import rs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rst_n_o,
  input logic              wake_pin_i,
  input logic              wake_cfg_o,
  input rs_state_t         st,
  input rs_src_t           src,
  input logic [STAT_W-1:0] stat
);
  // R2: wake configuration is applied as the reset output falls
  a_r2_wake_apply: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n_o) |-> wake_cfg_o == $past(wake_pin_i));

  // R5: release is preceded by the settle wait
  a_r5_settle_len: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> ($past(st, 1) == ST_SETTLE) && ($past(st, 4) == ST_SETTLE));

  // R7: checkstop completion leaves only the checkstop bit set
  a_r7_chk_status: assert property (@(posedge clk) disable iff (rst)
    ($rose(rst_n_o) && $past(src) == SRC_CHK) |-> stat[STAT_CHK:STAT_POR] == 2'b10);

  // R9: JTAG completion keeps the source bits
  a_r9_tap_status: assert property (@(posedge clk) disable iff (rst)
    ($rose(rst_n_o) && $past(src) == SRC_TAP) |->
      stat[STAT_CHK:STAT_POR] == $past(stat[STAT_CHK:STAT_POR]));

  // R10: the source of a running sequence never changes
  a_r10_src_stable: assert property (@(posedge clk) disable iff (rst)
    (!rst_n_o && $past(!rst_n_o)) |-> $stable(src));
endmodule

bind reset_sequencer rs_checker u_rs_chk (
  .clk(clk), .rst(rst), .rst_n_o(rst_n_o), .wake_pin_i(wake_pin_i),
  .wake_cfg_o(wake_cfg_o), .st(st), .src(src), .stat(stat)
);

// File: tb/sim_reset_sequencer.sv
`timescale 1ns/1ps
module sim_reset_sequencer;
  localparam int CNT = 6;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock = 1'b1, core_halt = 1'b0, tap_en = 1'b0, tap_bsel = 1'b0, strap = 1'b1;
  logic [4:0] pins = '0;
  logic reg_we = 1'b0, reg_addr = 1'b0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic rst_n_o, wake_cfg_o;
  logic [1:0] pll_cfg_o, boot_cfg_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  reset_sequencer #(.HOLD_CYCLES(CNT), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .pll_lock_i(lock), .core_halt_i(core_halt),
    .tap_en_i(tap_en), .tap_bsel_i(tap_bsel), .strap_cfg_i(strap),
    .wake_pin_i(pins[0]), .pll_pin_i(pins[2:1]), .boot_pin_i(pins[4:3]),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .rst_n_o(rst_n_o), .wake_cfg_o(wake_cfg_o),
    .pll_cfg_o(pll_cfg_o), .boot_cfg_o(boot_cfg_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic read_reg(input logic a, output int v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = int'(reg_rdata);
  endtask

  task automatic write_reg(input logic a, input logic [DW-1:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  // kind: 0 JTAG, 1 checkstop, 2 both together
  task automatic run_seq(input int kind, input int hold, input int lock_pre, input int drop_k,
                         input int inject_at, input bit chg, input logic [4:0] pb,
                         output int dur, output logic wk_f, output logic [1:0] pll_f);
    @(negedge clk);
    if (lock_pre > 0) lock = 1'b0;
    if (kind != 1) begin tap_en = 1'b1; tap_bsel = 1'b1; end
    if (kind != 0) core_halt = 1'b1;
    dur = 0; wk_f = 1'b0; pll_f = 2'b00;
    for (int i = 1; i < 400; i++) begin
      @(negedge clk);
      if (i == 1) begin wk_f = wake_cfg_o; pll_f = pll_cfg_o; core_halt = 1'b0; end
      if (i == hold) begin tap_en = 1'b0; tap_bsel = 1'b0; end
      if (lock_pre > 0 && i == lock_pre + 1) lock = 1'b1;
      if (drop_k > 0 && i == drop_k + 1) lock = 1'b0;
      if (drop_k > 0 && i == drop_k + 2) lock = 1'b1;
      if (inject_at > 0 && i == inject_at) core_halt = 1'b1;
      if (inject_at > 0 && i == inject_at + 1) core_halt = 1'b0;
      if (chg && i == 2) pins = pb;
      if (rst_n_o) break;
      dur++;
    end
    tap_en = 1'b0; tap_bsel = 1'b0; core_halt = 1'b0;
  endtask

  initial begin
    int v, dur, st_src;
    logic wk_f;
    logic [1:0] pll_f, e_pll, e_boot;
    logic e_wake;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: power-up sequence under way as rst drops
    check("R1 reset state rst_n", int'(rst_n_o), 0);
    dur = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rst_n_o) break;
      dur++;
    end
    check("R1 power-up length", dur, CNT + 4);
    read_reg(1'b1, v);
    check("R1 status after power-up", v, 1);
    read_reg(1'b0, v);
    check("R12 control reset value", v, 0);

    e_pll = 2'b00; e_boot = 2'b00; st_src = 1;

    // R6: checkstop ignored while enable bit is clear
    @(negedge clk); core_halt = 1'b1;
    v = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (!rst_n_o) v++; end
    core_halt = 1'b0;
    check("R6 disabled checkstop ignored", v, 0);

    // R8: tap request without enable ignored
    @(negedge clk); tap_bsel = 1'b1;
    v = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (!rst_n_o) v++; end
    tap_bsel = 1'b0;
    check("R8 request ignored when tap disabled", v, 0);

    // R2 R4 R9: sweep of strap and every pin pattern via JTAG resets
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 32; p++) begin
        logic [4:0] pa, pb;
        pa = 5'(p); pb = ~pa;
        strap = s[0];
        @(negedge clk); pins = pa;
        run_seq(0, 1, 0, 0, 0, 1'b1, pb, dur, wk_f, pll_f);
        if (strap) e_pll = pa[2:1];
        e_wake = pb[0];
        if (strap) e_boot = pb[4:3];
        check("R2 wake applied at start", int'(wk_f), int'(pa[0]));
        check("R2 pll applied at start", int'(pll_f), int'(e_pll));
        check("R8 JTAG hold 1 length", dur, 1 + CNT + 4);
        check("R4 wake sampled at count end", int'(wake_cfg_o), int'(e_wake));
        check("R4 boot sampled at count end", int'(boot_cfg_o), int'(e_boot));
        check("R2 pll unchanged after start", int'(pll_cfg_o), int'(e_pll));
        read_reg(1'b1, v);
        check("R9 status after JTAG reset", v, int'({e_boot, e_wake}) * 4 + st_src);
      end
    end
    strap = 1'b1;

    // R12: control readback, status write ignored
    write_reg(1'b0, 8'hA5);
    read_reg(1'b0, v);
    check("R12 control readback", v, 8'hA5);
    write_reg(1'b1, 8'hFF);
    read_reg(1'b1, v);
    check("R12 status ignores writes", v, int'({e_boot, e_wake}) * 4 + st_src);

    // R11: both at once, JTAG held 4 cycles; checkstop wins and does not wait
    run_seq(2, 4, 0, 0, 0, 1'b0, 5'd0, dur, wk_f, pll_f);
    check("R11 priority length", dur, CNT + 5);
    st_src = 2;
    read_reg(1'b1, v);
    check("R11 R7 status after checkstop", v & 3, st_src);

    // R5 R7: plain checkstop
    run_seq(1, 0, 0, 0, 0, 1'b0, 5'd0, dur, wk_f, pll_f);
    check("R5 checkstop length", dur, CNT + 5);
    read_reg(1'b1, v);
    check("R7 checkstop status", v & 3, 2);

    // R8: JTAG held 5 cycles
    run_seq(0, 5, 0, 0, 0, 1'b0, 5'd0, dur, wk_f, pll_f);
    check("R8 JTAG hold 5 length", dur, 5 + CNT + 4);
    read_reg(1'b1, v);
    check("R9 source bits kept", v & 3, 2);

    // R3: lock low before counting, and lock drop during count
    for (int l = 1; l < 5; l++) begin
      run_seq(1, 0, l, 0, 0, 1'b0, 5'd0, dur, wk_f, pll_f);
      check("R3 lock late length", dur, CNT + 5 + l);
    end
    for (int k = 1; k <= CNT; k++) begin
      run_seq(1, 0, 0, k, 0, 1'b0, 5'd0, dur, wk_f, pll_f);
      check("R3 lock drop restart length", dur, CNT + 5 + k + 1);
    end

    // R10: checkstop pulse during a JTAG sequence is ignored
    run_seq(1, 0, 0, 0, 0, 1'b0, 5'd0, dur, wk_f, pll_f);
    write_reg(1'b0, 8'h01);
    run_seq(0, 1, 0, 0, 3, 1'b0, 5'd0, dur, wk_f, pll_f);
    check("R10 length unchanged by late request", dur, 1 + CNT + 4);
    @(negedge clk);
    check("R10 no second sequence", int'(rst_n_o), 1);
    read_reg(1'b1, v);
    check("R10 status source unchanged", v & 3, 2);

    finish_run();
  end
endmodule